// File: doc/BRIEF.md
# Consumer-Electronics-Control Bus Receiver

This block listens to the already filtered single-wire control bus of a display link and turns the waveform into received blocks. Every timing decision is counted in ticks. The tick is a clock enable supplied by the surrounding logic. A start bit is accepted only when its low phase and its full period both fall inside programmable windows. The block then takes in ten bits per block: eight data bits with the most significant bit first, an end-of-message flag and an acknowledge slot. Each data bit is resolved from the line level at a programmable sample point after its falling edge. A data bit that is held low too long, or whose period falls outside the window, aborts the frame.

The low nibble of the first byte of a frame names the destination. The frame is taken into the receive register if the destination is set in a 15-bit address mask, if it is the broadcast address 15, or if snoop is enabled. For frames sent directly to a mask address, the block holds the line low during the acknowledge slot, unless NAK mode is selected. Events are collected in a write-1-to-clear status word. The receive register is read as a 16-bit word.

A frame ends quietly when the line stays high for the end-of-block idle time after an acknowledge slot. After that, only a new valid start bit opens a frame.

Top module: `cec_rx`

## Requirements
- R1: After reset the status word, the receive word and the acknowledge drive output are all zero.
- R2: A start bit is valid when its low time lies in [start field 15:8, start field 7:0] and the next falling edge arrives in [start field 31:24, start field 23:16] ticks. A valid start sets status bit 10. Any other start sets status bit 11 (anomaly), stores nothing and returns to idle.
- R3: Each data bit is the line level at the tick count given in data-timing field 15:8, with high meaning 1, and bits arrive MSB first. A completed block is written to the receive word as byte in bits 7:0, end-of-message in bit 8 and the sampled acknowledge level in bit 9, and it sets status bit 8 (full).
- R4: If a data bit stays low longer than data field 7:0, or its period lies outside [data field 31:24, data field 23:16], the block sets status bit 12 (bus error), abandons the frame and stores nothing.
- R5: The destination is bits 3:0 of the first byte. A frame is stored if control bit d of mask 14:0 is set, if the destination is 15, or if control bit 15 (snoop) is set. Otherwise the receive word and status bit 8 are left as they were.
- R6: For a frame with its destination bit set in the mask, not broadcast, and control bit 16 (NAK mode) clear, ack_drive_o is high for misc field 15:8 ticks starting at the acknowledge slot falling edge, and the stored acknowledge bit reads 0. In every other case ack_drive_o stays low.
- R7: A block that completes while status bit 8 is set sets status bit 9 (overrun) and leaves the receive word unchanged.
- R8: A receive-read strobe, or writing 1 to status bit 8, clears the full bit.
- R9: Writing 1 to a status bit clears it and writing 0 leaves it. Bits 13 and 14 record falling and rising line edges.
- R10: After an acknowledge slot, a line held high for misc field 7:0 ticks ends the frame with no error flag, and a following frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timing tick enable |
| line_i | input | 1 | Filtered bus level |
| ctrl_i | input | 17 | Address mask 14:0, snoop 15, NAK mode 16 |
| start_tmg_i | input | 32 | Start windows: max low, min low, max period, min period (LSB up) |
| bit_tmg_i | input | 32 | Data windows: max low, sample point, max period, min period (LSB up) |
| misc_tmg_i | input | 16 | End-of-block idle 7:0, acknowledge low time 15:8 |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 16 | Write-1-to-clear mask |
| rx_rd_i | input | 1 | Receive word read strobe |
| rx_data_o | output | 16 | Receive word |
| stat_o | output | 16 | Status word, bits 14:8 used |
| ack_drive_o | output | 1 | High pulls the bus low |

## Verification
A wrong bit index or a stale shift register shows up as a corrupted byte or end-of-message bit as soon as the block completes, roughly ten bit periods after the start. A latched address decision that goes wrong shows up on the second block of a frame as an acknowledge pulse that is missing or unexpected. A window comparison that is off by one flips the anomaly or bus-error status bit at the edge that closes the window. A slip in the full/overrun bookkeeping alters the receive word on the very next completed block.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_START = 2'd1,
    S_BITS  = 2'd2
  } rx_state_e;

  // status bit offsets relative to STAT_BASE
  localparam int unsigned STAT_BASE = 8;
  localparam int unsigned STAT_NB   = 7;
  localparam int unsigned SB_FULL   = 0;
  localparam int unsigned SB_OVR    = 1;
  localparam int unsigned SB_START  = 2;
  localparam int unsigned SB_ANOM   = 3;
  localparam int unsigned SB_BERR   = 4;
  localparam int unsigned SB_FALL   = 5;
  localparam int unsigned SB_RISE   = 6;
endpackage

// File: rtl/cec_rx_edge.sv
module cec_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic fall_o,
  output logic rise_o
);
  logic line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= line_i;
  end

  assign fall_o = line_q & ~line_i;
  assign rise_o = ~line_q & line_i;
endmodule

// File: rtl/cec_rx_timer.sv
module cec_rx_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          lvl_i,
  input  logic          fall_i,
  input  logic          rise_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] hi_o
);
  localparam logic [CW-1:0] ONE_TICK = CW'(1);

  logic [CW-1:0] cnt_q, cnt_n, hi_q, hi_n;

  always_comb begin
    cnt_n = cnt_q;
    if (fall_i)                 cnt_n = tick_i ? ONE_TICK : '0;
    else if (tick_i && !(&cnt_q)) cnt_n = cnt_q + ONE_TICK;

    hi_n = hi_q;
    if (fall_i)                         hi_n = '0;
    else if (rise_i)                    hi_n = tick_i ? ONE_TICK : '0;
    else if (tick_i && lvl_i && !(&hi_q)) hi_n = hi_q + ONE_TICK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= '0;
    end else begin
      cnt_q <= cnt_n;
      hi_q  <= hi_n;
    end
  end

  assign cnt_o = cnt_q;
  assign hi_o  = hi_q;

  a_r10_hi_zero_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fall_i) |-> (hi_q == '0));
endmodule

// File: rtl/cec_rx_status.sv
module cec_rx_status #(
  parameter int NB   = 7,
  parameter int BASE = 8,
  parameter int W    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rd_i,
  output logic [W-1:0]  stat_o
);
  logic [NB-1:0] st_q, st_n;

  for (genvar i = 0; i < NB; i++) begin : g_bit
    logic clr;
    if (i == 0) begin : g_full
      assign clr = (wr_i & wdata_i[BASE+i]) | rd_i;
    end else begin : g_plain
      assign clr = wr_i & wdata_i[BASE+i];
    end
    assign st_n[i] = set_i[i] | (st_q[i] & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_n;
  end

  always_comb begin
    stat_o = '0;
    stat_o[BASE +: NB] = st_q;
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[BASE-1:0], wdata_i[W-1:BASE+NB]};

  a_r8_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !set_i[0]) |=> !st_q[0]);
endmodule

// File: rtl/cec_rx.sv
module cec_rx
  import cec_rx_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_i,
  input  logic                    line_i,
  input  logic [(1<<AW):0]        ctrl_i,
  input  logic [4*CW-1:0]         start_tmg_i,
  input  logic [4*CW-1:0]         bit_tmg_i,
  input  logic [2*CW-1:0]         misc_tmg_i,
  input  logic                    stat_wr_i,
  input  logic [15:0]             stat_wdata_i,
  input  logic                    rx_rd_i,
  output logic [15:0]             rx_data_o,
  output logic [15:0]             stat_o,
  output logic                    ack_drive_o
);
  localparam int NLA    = (1 << AW) - 1;
  localparam int NDATA  = 8;
  localparam int RXW    = NDATA + 2;
  localparam int BW     = $clog2(NDATA + 2);
  localparam logic [AW-1:0] BCAST   = AW'(NLA);
  localparam logic [BW-1:0] EOM_IDX = BW'(NDATA);
  localparam logic [BW-1:0] ACK_IDX = BW'(NDATA + 1);

  // timing fields
  logic [CW-1:0] s_maxlo, s_minlo, s_maxp, s_minp;
  logic [CW-1:0] d_maxlo, d_smp, d_maxp, d_minp, eob_t, ack_lo;
  assign {s_minp, s_maxp, s_minlo, s_maxlo} = start_tmg_i;
  assign {d_minp, d_maxp, d_smp, d_maxlo}   = bit_tmg_i;
  assign {ack_lo, eob_t}                    = misc_tmg_i;

  logic snoop, nak;
  logic [NLA:0] mask_w;
  assign mask_w = {1'b0, ctrl_i[NLA-1:0]};
  assign snoop  = ctrl_i[NLA];
  assign nak    = ctrl_i[NLA+1];

  logic fall, rise;
  logic [CW-1:0] cnt, hi;
  logic [STAT_NB-1:0] set_v;
  logic full;

  cec_rx_edge u_edge (.clk(clk), .rst_n(rst_n), .line_i(line_i), .fall_o(fall), .rise_o(rise));

  cec_rx_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .lvl_i(line_i),
    .fall_i(fall), .rise_i(rise), .cnt_o(cnt), .hi_o(hi));

  cec_rx_status #(.NB(STAT_NB), .BASE(STAT_BASE), .W(16)) u_status (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .wr_i(stat_wr_i),
    .wdata_i(stat_wdata_i), .rd_i(rx_rd_i), .stat_o(stat_o));

  assign full = stat_o[STAT_BASE + SB_FULL];

  rx_state_e st_q, st_n;
  logic [BW-1:0]    bidx_q, bidx_n;
  logic [NDATA-1:0] sh_q, sh_n;
  logic [RXW-1:0]   rx_q, rx_n;
  logic gap_q, gap_n, eom_q, eom_n, first_q, first_n;
  logic acc_q, acc_n, drv_q, drv_n, ack_q, ack_n;

  logic [AW-1:0] dest;
  logic hit, acc_now, drv_now, p_ok;
  assign dest    = sh_q[AW-1:0];
  assign hit     = mask_w[dest];
  assign acc_now = first_q ? (snoop | (dest == BCAST) | hit) : acc_q;
  assign drv_now = first_q ? (hit & ~nak) : drv_q;
  assign p_ok    = (cnt >= d_minp) && (cnt <= d_maxp);

  always_comb begin
    st_n = st_q; bidx_n = bidx_q; sh_n = sh_q; rx_n = rx_q;
    gap_n = gap_q; eom_n = eom_q; first_n = first_q;
    acc_n = acc_q; drv_n = drv_q;
    ack_n = ack_q & (cnt < ack_lo);
    set_v = '0;
    set_v[SB_FALL] = fall;
    set_v[SB_RISE] = rise;
    unique case (st_q)
      S_IDLE: if (fall) st_n = S_START;
      S_START: begin
        if (fall) begin
          if (cnt >= s_minp && cnt <= s_maxp) begin
            st_n = S_BITS; set_v[SB_START] = 1'b1;
            bidx_n = '0; gap_n = 1'b0; first_n = 1'b1;
          end else begin
            st_n = S_IDLE; set_v[SB_ANOM] = 1'b1;
          end
        end else if ((rise && cnt < s_minlo) || (!line_i && cnt > s_maxlo) ||
                     (line_i && cnt > s_maxp)) begin
          st_n = S_IDLE; set_v[SB_ANOM] = 1'b1;
        end
      end
      S_BITS: begin
        if (fall) begin
          if (!p_ok) begin
            st_n = S_IDLE; set_v[SB_BERR] = 1'b1; ack_n = 1'b0;
          end else if (gap_q) begin
            bidx_n = '0; gap_n = 1'b0;
          end else begin
            bidx_n = bidx_q + BW'(1);
            if (bidx_q == EOM_IDX && drv_now) ack_n = 1'b1;
          end
        end else if ((!line_i && cnt > d_maxlo) || (line_i && !gap_q && cnt > d_maxp)) begin
          st_n = S_IDLE; set_v[SB_BERR] = 1'b1; ack_n = 1'b0;
        end else if (line_i && gap_q && hi >= eob_t) begin
          st_n = S_IDLE;
        end else if (tick_i && !gap_q && cnt == d_smp) begin
          if (bidx_q < EOM_IDX) sh_n = {sh_q[NDATA-2:0], line_i};
          else if (bidx_q == EOM_IDX) eom_n = line_i;
          else begin
            gap_n = 1'b1; first_n = 1'b0;
            acc_n = acc_now; drv_n = drv_now;
            if (acc_now) begin
              if (full) set_v[SB_OVR] = 1'b1;
              else begin
                rx_n = {line_i, eom_q, sh_q};
                set_v[SB_FULL] = 1'b1;
              end
            end
          end
        end
      end
      default: st_n = S_IDLE;
    endcase
    if (st_n == S_IDLE) ack_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; bidx_q <= '0; sh_q <= '0; rx_q <= '0;
      gap_q <= 1'b0; eom_q <= 1'b0; first_q <= 1'b0;
      acc_q <= 1'b0; drv_q <= 1'b0; ack_q <= 1'b0;
    end else begin
      st_q <= st_n; bidx_q <= bidx_n; sh_q <= sh_n; rx_q <= rx_n;
      gap_q <= gap_n; eom_q <= eom_n; first_q <= first_n;
      acc_q <= acc_n; drv_q <= drv_n; ack_q <= ack_n;
    end
  end

  assign rx_data_o   = {{(16-RXW){1'b0}}, rx_q};
  assign ack_drive_o = ack_q;

  a_r6_ack_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (st_q == S_BITS));
  a_r6_ack_width: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (cnt <= ack_lo));
  a_r7_rx_held_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $stable(rx_q));
  a_r7_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[STAT_BASE + SB_OVR]) |-> $past(full));
  a_r4_berr_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[STAT_BASE + SB_BERR]) |-> (st_q == S_IDLE));
  a_r2_start_enters_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[STAT_BASE + SB_START]) |-> (st_q == S_BITS));
endmodule

// File: tb/cec_rx_bench.sv
module cec_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snd = 1'b1;
  logic [16:0] ctrl = 17'h00010;
  logic stat_wr = 1'b0, rx_rd = 1'b0;
  logic [15:0] stat_wdata = '0;
  logic [15:0] rx_data, stat;
  logic ack_drv, line_w;
  int checks = 0, errors = 0, ack_cnt = 0;
  logic [15:0] exp_rx;

  always #10 clk = ~clk;
  assign line_w = snd & ~ack_drv;

  cec_rx u_cec_rx (
    .clk(clk), .rst_n(rst_n), .tick_i(1'b1), .line_i(line_w), .ctrl_i(ctrl),
    .start_tmg_i({8'h86, 8'h93, 8'h6D, 8'h7A}),
    .bit_tmg_i({8'h40, 8'h56, 8'h21, 8'h35}),
    .misc_tmg_i({8'h28, 8'h50}),
    .stat_wr_i(stat_wr), .stat_wdata_i(stat_wdata), .rx_rd_i(rx_rd),
    .rx_data_o(rx_data), .stat_o(stat), .ack_drive_o(ack_drv));

  always @(negedge clk) if (ack_drv === 1'b1) ack_cnt++;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic lohi(input int lo, input int per);
    snd = 1'b0; repeat (lo) @(negedge clk);
    snd = 1'b1; repeat (per - lo) @(negedge clk);
  endtask

  task automatic send_bit(input logic v);
    lohi(v ? int'($urandom_range(28, 10)) : int'($urandom_range(50, 38)), int'($urandom_range(84, 66)));
  endtask

  task automatic send_start();
    lohi(int'($urandom_range(121, 110)), int'($urandom_range(146, 135)));
  endtask

  task automatic send_block(input logic [7:0] b, input logic eom);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    send_bit(eom);
    send_bit(1'b1);
  endtask

  task automatic idle(input int n);
    snd = 1'b1; repeat (n) @(negedge clk);
  endtask

  task automatic wr_stat(input logic [15:0] d);
    stat_wr = 1'b1; stat_wdata = d; @(negedge clk);
    stat_wr = 1'b0; stat_wdata = '0; @(negedge clk);
  endtask

  task automatic rd_rx();
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0; @(negedge clk);
  endtask

  function automatic logic f_acc(input logic [3:0] d, input logic [16:0] c);
    return c[15] || d == 4'hF || (d != 4'hF && c[d]);
  endfunction

  function automatic logic f_drv(input logic [3:0] d, input logic [16:0] c);
    return d != 4'hF && c[d] && !c[16];
  endfunction

  function automatic logic [15:0] f_rx(input logic [7:0] b, input logic eom, input logic drv);
    return {6'b0, !drv, eom, b};
  endfunction

  task automatic frame1(input logic [7:0] b);
    ack_cnt = 0;
    send_start(); send_block(b, 1'b1); idle(250);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 stat", stat, 16'h0000);
    chk("R1 rx", rx_data, 16'h0000);
    chk("R1 ack", {15'b0, ack_drv}, 16'h0000);
    rst_n = 1'b1;
    idle(20);

    // R3 R6 R10: direct frame to address 4, ends quietly
    frame1(8'h34);
    chk("R3 rx word", rx_data, 16'h0134);
    chk("R10 stat no error", stat, 16'h6500);
    chk("R6 ack ticks", 16'(ack_cnt), 16'd40);

    // R9 write-one-to-clear, R8 read clears full
    wr_stat(16'h0400);
    chk("R9 w1c one bit", stat, 16'h6100);
    wr_stat(16'h0000);
    chk("R9 zero write", stat, 16'h6100);
    rd_rx();
    chk("R8 read clears full", stat, 16'h6000);
    wr_stat(16'h7F00);

    // R7 overrun on two-block frame
    ack_cnt = 0;
    send_start(); send_block(8'h34, 1'b0); send_block(8'hA5, 1'b1); idle(250);
    chk("R7 rx kept", rx_data, 16'h0034);
    chk("R7 stat overrun", stat, 16'h6700);
    chk("R6 ack latched second block", 16'(ack_cnt), 16'd80);
    wr_stat(16'h0100);
    chk("R8 w1c full", stat, 16'h6600);
    wr_stat(16'h7F00);
    exp_rx = 16'h0034;

    // R5 non-matching destination ignored
    frame1(8'h53);
    chk("R5 rx unchanged", rx_data, exp_rx);
    chk("R5 full clear", stat & 16'h0100, 16'h0000);
    chk("R6 no ack non-match", 16'(ack_cnt), 16'd0);
    wr_stat(16'h7F00);

    // R5 snoop
    ctrl = 17'h08010;
    frame1(8'h53);
    chk("R5 snoop stored", rx_data, 16'h0353);
    chk("R6 no ack snoop", 16'(ack_cnt), 16'd0);
    rd_rx(); wr_stat(16'h7F00);

    // R5 R6 broadcast
    ctrl = 17'h00010;
    frame1(8'h4F);
    chk("R5 broadcast stored", rx_data, 16'h034F);
    chk("R6 no ack broadcast", 16'(ack_cnt), 16'd0);
    rd_rx(); wr_stat(16'h7F00);

    // R6 NAK mode
    ctrl = 17'h10010;
    frame1(8'h24);
    chk("R6 nak stored", rx_data, 16'h0324);
    chk("R6 no ack nak", 16'(ack_cnt), 16'd0);
    rd_rx(); wr_stat(16'h7F00);
    ctrl = 17'h00010;
    exp_rx = 16'h0324;

    // R2 start low too short
    lohi(100, 141); idle(250);
    chk("R2 short start", stat & 16'h1D00, 16'h0800);
    wr_stat(16'h7F00);
    // R2 start period too long
    lohi(116, 400);
    chk("R2 long start period", stat & 16'h1D00, 16'h0800);
    wr_stat(16'h7F00);

    // R4 data bit low too long
    send_start(); lohi(60, 300);
    chk("R4 long low", stat, 16'h7400);
    chk("R4 nothing stored", rx_data, exp_rx);
    wr_stat(16'h7F00);
    // R4 data bit period too short
    send_start(); lohi(19, 55); idle(300);
    chk("R4 short period", stat & 16'h1100, 16'h1000);
    wr_stat(16'h7F00);

    // R10 frame after errors still received
    frame1(8'hE4);
    chk("R10 recover", rx_data, 16'h01E4);
    rd_rx(); wr_stat(16'h7F00);

    // random single-block frames: R3 R5 R6
    for (int n = 0; n < 14; n++) begin
      logic [7:0] b;
      logic a, d;
      b = 8'($urandom());
      ctrl = {($urandom_range(3, 0) == 0), ($urandom_range(3, 0) == 0), 15'($urandom())};
      a = f_acc(b[3:0], ctrl);
      d = f_drv(b[3:0], ctrl);
      if (a) exp_rx = f_rx(b, 1'b1, d);
      frame1(b);
      chk("R3 R5 random rx", rx_data, exp_rx);
      chk("R5 random stat", stat, a ? 16'h6500 : 16'h6400);
      chk("R6 random ack", 16'(ack_cnt), d ? 16'd40 : 16'd0);
      rd_rx(); wr_stat(16'h7F00);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule